// File: doc/BRIEF.md
# Configuration Image Loader

The loader accepts a device configuration image as a stream of 32-bit words and plays it out to a target device over a byte-wide configuration port. Words reach an internal word FIFO through a write window on a simple register bus. They are written either by the processor or by an external DMA engine that the loader paces with a request line. A word is consumed from the FIFO when the serializer takes it. Each consumed word adds four to a running byte count, and that count is compared with a total byte count that software loads beforehand.

The load sequencer has four named states. IDLE moves to LOAD when software writes the control register with enable set and reset clear. LOAD moves to FINISH on an error, or when the running count has reached the total, the serializer is idle and the target reports done. If the count has been reached but the target is not yet done, LOAD moves to WAIT_DONE. WAIT_DONE moves to FINISH on target done or on an error. FINISH drives the interrupt. A control write of zero returns the sequencer to IDLE from any state, clears the interrupt and flushes the FIFO and the serializer.

Register offsets: control 0x40 (bit 0 enable, bit 1 target reset, bit 2 DMA pacing), status 0x44, FIFO capacity 0x48, FIFO fill 0x4C, total byte count 0x50, running byte count 0x54, FIFO write window 0x3000.

Top module: `cfgl_top`

## Requirements
- R1: After reset, irq, dma_req, cfg_valid and cfg_rst are low, and status, running count and FIFO fill all read zero while cfg_done is low.
- R2: The capacity register reads FIFO_DEPTH*4 bytes. The fill register reads 4 times the number of words held.
- R3: A write to the total byte count is taken only while control enable is clear. While enable is set, such a write leaves the register unchanged.
- R4: Each consumed word goes out as four bytes on four cycles with cfg_valid high, most significant byte first.
- R5: The running count is cleared on start and grows by 4 for each word consumed. No word is consumed once the count equals the total, and any extra words stay in the FIFO.
- R6: When the count equals the total, the serializer is idle and cfg_done is high, the sequencer enters FINISH with status bit 0 set and irq high. While cfg_done stays low it waits in WAIT_DONE with irq low.
- R7: cfg_err high during LOAD or WAIT_DONE sets status bit 1 and ends the load in FINISH with irq high and status bit 0 clear.
- R8: A window write while the FIFO is full is dropped and sets status bit 2. Status bits 15:1 are cleared on start.
- R9: irq stays high in FINISH until the control register is written with value zero. Writing any other control value leaves it high.
- R10: cfg_rst is high exactly while the control register holds both enable and reset. Writing 3 and then 0 pulses it.
- R11: dma_req rises only in LOAD with enable and DMA pacing set and at least FIFO_DEPTH/2 words free. It drops after FIFO_DEPTH/2 window writes, and it stays low in processor mode.
- R12: Status bit 18 mirrors the cfg_done input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| dma_req | output | 1 | Burst request to the external DMA engine |
| cfg_data | output | 8 | Configuration byte to the target |
| cfg_valid | output | 1 | cfg_data carries a byte this cycle |
| cfg_rst | output | 1 | Reset line to the target |
| cfg_done | input | 1 | Target reports configuration done |
| cfg_err | input | 1 | Target reports a configuration error |
| irq | output | 1 | Load finished or failed |

## Verification
The assertions assume that software writes the total byte count only while the loader is disabled. They also assume that no window write and no control write land in the same cycle, and that the target accepts a byte on every cycle in which cfg_valid is high. The directed tasks drive one bus write at a time, two cycles apart, and set the total before enabling. The bench models the DMA engine by answering each rising dma_req with exactly FIFO_DEPTH/2 window writes, so a burst never exceeds the free space that the request promised.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;
    typedef enum logic [1:0] {S_IDLE, S_LOAD, S_WAIT_DONE, S_FINISH} load_state_e;
    typedef enum logic {R_IDLE, R_BURST} req_state_e;

    localparam int OFF_CTRL  = 'h40;
    localparam int OFF_STAT  = 'h44;
    localparam int OFF_SIZE  = 'h48;
    localparam int OFF_USED  = 'h4C;
    localparam int OFF_TOTAL = 'h50;
    localparam int OFF_CUR   = 'h54;
    localparam int OFF_WIN   = 'h3000;

    localparam int CB_EN  = 0;
    localparam int CB_RST = 1;
    localparam int CB_DMA = 2;

    localparam int SB_OK   = 0;
    localparam int SB_TGT  = 1;
    localparam int SB_OVF  = 2;
    localparam int SB_DONE = 18;
endpackage

// File: rtl/cfgl_fifo.sv
module cfgl_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic          full,
    output logic          empty,
    output logic [LW-1:0] level
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic do_push, do_pop;

    assign full    = (level == LW'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full && !clear;
    assign do_pop  = pop && !empty && !clear;
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp <= '0; rp <= '0; level <= '0;
        end else if (clear) begin
            wp <= '0; rp <= '0; level <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
            level <= level + LW'(do_push) - LW'(do_pop);
        end
    end

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push) |=> (level <= $past(level)));
endmodule

// File: rtl/cfgl_serializer.sv
module cfgl_serializer (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        word_avail,
    input  logic [31:0] word_in,
    output logic        pop,
    output logic [7:0]  byte_out,
    output logic        byte_valid,
    output logic        busy
);
    logic [31:0] sh;
    logic [1:0]  cnt;
    logic        last;

    assign last       = busy && (cnt == 2'd3);
    assign pop        = word_avail && (!busy || last) && !clear;
    assign byte_out   = sh[31:24];
    assign byte_valid = busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh <= '0; cnt <= '0; busy <= 1'b0;
        end else if (clear) begin
            cnt <= '0; busy <= 1'b0;
        end else if (pop) begin
            sh <= word_in; cnt <= '0; busy <= 1'b1;
        end else if (busy) begin
            sh  <= {sh[23:0], 8'h00};
            cnt <= cnt + 1'b1;
            if (last) busy <= 1'b0;
        end
    end
endmodule

// File: rtl/cfgl_dma_req.sv
module cfgl_dma_req #(
    parameter int HALF = 8,
    parameter int LW   = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm,
    input  logic [LW-1:0] free_words,
    input  logic          beat,
    output logic          req
);
    import cfgl_pkg::*;
    req_state_e st_q, st_d;
    logic [LW-1:0] cnt;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            R_IDLE:  if (arm && free_words >= LW'(HALF)) st_d = R_BURST;
            R_BURST: if (!arm || (beat && cnt == LW'(HALF-1))) st_d = R_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= R_IDLE; cnt <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == R_IDLE) cnt <= '0;
            else if (beat)      cnt <= cnt + 1'b1;
        end
    end

    always_comb req = (st_q == R_BURST);
endmodule

// File: rtl/cfgl_top.sv
module cfgl_top #(
    parameter int FIFO_DEPTH = 16,
    parameter int ADDR_W     = 14,
    localparam int LW        = $clog2(FIFO_DEPTH) + 1,
    localparam int HALF      = FIFO_DEPTH / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              dma_req,
    output logic [7:0]        cfg_data,
    output logic              cfg_valid,
    output logic              cfg_rst,
    input  logic              cfg_done,
    input  logic              cfg_err,
    output logic              irq
);
    import cfgl_pkg::*;

    load_state_e st_q, st_d;
    logic ctrl_en, ctrl_rst, ctrl_dma;
    logic [31:0] total_q, cur_q;
    logic err_tgt, err_ovf, ok_flag, err_any;
    logic ctrl_wr, wzero, start, win_wr, ovf_evt;
    logic fifo_full, fifo_empty, pop, ser_busy, word_avail, loading;
    logic [31:0] fifo_dout, stat;
    logic [LW-1:0] level;

    assign ctrl_wr = bus_we && (bus_addr == ADDR_W'(OFF_CTRL));
    assign wzero   = ctrl_wr && (bus_wdata[2:0] == 3'b000);
    assign start   = ctrl_wr && bus_wdata[CB_EN] && !bus_wdata[CB_RST] && (st_q == S_IDLE);
    assign win_wr  = bus_we && (bus_addr == ADDR_W'(OFF_WIN));
    assign ovf_evt = win_wr && fifo_full;
    assign err_any = err_tgt || err_ovf;
    assign loading = (st_q == S_LOAD) || (st_q == S_WAIT_DONE);
    assign word_avail = (st_q == S_LOAD) && !fifo_empty && (cur_q < total_q);

    cfgl_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .clear(wzero), .push(win_wr), .din(bus_wdata),
        .pop(pop), .dout(fifo_dout), .full(fifo_full), .empty(fifo_empty), .level(level));

    cfgl_serializer u_ser (
        .clk(clk), .rst_n(rst_n), .clear(wzero), .word_avail(word_avail),
        .word_in(fifo_dout), .pop(pop), .byte_out(cfg_data), .byte_valid(cfg_valid),
        .busy(ser_busy));

    cfgl_dma_req #(.HALF(HALF), .LW(LW)) u_req (
        .clk(clk), .rst_n(rst_n),
        .arm(ctrl_en && ctrl_dma && (st_q == S_LOAD)),
        .free_words(LW'(FIFO_DEPTH) - level), .beat(win_wr), .req(dma_req));

    always_comb begin
        st_d = st_q;
        if (wzero) st_d = S_IDLE;
        else begin
            unique case (st_q)
                S_IDLE:      if (start) st_d = S_LOAD;
                S_LOAD:      if (err_any) st_d = S_FINISH;
                             else if (cur_q == total_q && !ser_busy)
                                 st_d = cfg_done ? S_FINISH : S_WAIT_DONE;
                S_WAIT_DONE: if (err_any || cfg_done) st_d = S_FINISH;
                S_FINISH:    st_d = S_FINISH;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= S_IDLE;
            ctrl_en <= 1'b0; ctrl_rst <= 1'b0; ctrl_dma <= 1'b0;
            total_q <= '0; cur_q <= '0;
            err_tgt <= 1'b0; err_ovf <= 1'b0; ok_flag <= 1'b0;
        end else begin
            st_q <= st_d;
            if (ctrl_wr) begin
                ctrl_en  <= bus_wdata[CB_EN];
                ctrl_rst <= bus_wdata[CB_RST];
                ctrl_dma <= bus_wdata[CB_DMA];
            end
            if (bus_we && bus_addr == ADDR_W'(OFF_TOTAL) && !ctrl_en) total_q <= bus_wdata;
            if (start) begin
                cur_q <= '0; err_tgt <= 1'b0; err_ovf <= 1'b0; ok_flag <= 1'b0;
            end else begin
                if (pop) cur_q <= cur_q + 32'd4;
                if (cfg_err && loading) err_tgt <= 1'b1;
                if (ovf_evt) err_ovf <= 1'b1;
                if (loading && st_d == S_FINISH && !err_any) ok_flag <= 1'b1;
            end
        end
    end

    always_comb begin
        irq     = (st_q == S_FINISH);
        cfg_rst = ctrl_en && ctrl_rst;
        stat = '0;
        stat[SB_OK]   = ok_flag;
        stat[SB_TGT]  = err_tgt;
        stat[SB_OVF]  = err_ovf;
        stat[SB_DONE] = cfg_done;
        unique case (bus_addr)
            ADDR_W'(OFF_CTRL):  bus_rdata = {29'b0, ctrl_dma, ctrl_rst, ctrl_en};
            ADDR_W'(OFF_STAT):  bus_rdata = stat;
            ADDR_W'(OFF_SIZE):  bus_rdata = 32'(FIFO_DEPTH * 4);
            ADDR_W'(OFF_USED):  bus_rdata = 32'({level, 2'b00});
            ADDR_W'(OFF_TOTAL): bus_rdata = total_q;
            ADDR_W'(OFF_CUR):   bus_rdata = cur_q;
            default:            bus_rdata = '0;
        endcase
    end

    assert_irq_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !wzero) |=> irq);
    assert_cur_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_q) |-> (cur_q == $past(cur_q) + 32'd4 || cur_q == '0));
    assert_cur_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_LOAD) |-> (cur_q <= total_q));
    assert_dma_mode_R11: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> (ctrl_en && ctrl_dma));
endmodule

// File: tb/tb_cfgl_top.sv
module tb_cfgl_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;
    localparam logic [13:0] A_CTRL = 14'h40, A_STAT = 14'h44, A_SIZE = 14'h48,
                            A_USED = 14'h4C, A_TOTAL = 14'h50, A_CUR = 14'h54, A_WIN = 14'h3000;

    logic clk = 0, rst_n = 0, bus_we = 0, cfg_done = 0, cfg_err = 0;
    logic [13:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic dma_req, cfg_valid, cfg_rst, irq;
    logic [7:0] cfg_data;
    int checks = 0, errors = 0;
    logic [7:0] cap [512];
    int ncap = 0;
    int req_cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfgl_top #(.FIFO_DEPTH(DEPTH), .ADDR_W(14)) dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dma_req(dma_req),
        .cfg_data(cfg_data), .cfg_valid(cfg_valid), .cfg_rst(cfg_rst),
        .cfg_done(cfg_done), .cfg_err(cfg_err), .irq(irq));

    always @(negedge clk) begin
        if (rst_n && cfg_valid && ncap < 512) begin cap[ncap] = cfg_data; ncap++; end
        if (rst_n && dma_req) req_cycles++;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [13:0] a, input logic [31:0] d);
        @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_we = 0;
    endtask

    task automatic rd(input logic [13:0] a, output logic [31:0] d);
        @(negedge clk); bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic wait_irq(input int lim, output bit got);
        got = 0;
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if (irq) begin got = 1; break; end
        end
    endtask

    task automatic test_reset;
        logic [31:0] v;
        chk(!irq && !dma_req && !cfg_valid && !cfg_rst, "R1 outputs", {irq, dma_req, cfg_valid, cfg_rst}, 0);
        rd(A_STAT, v); chk(v == 0, "R1 status", v, 0);
        rd(A_CUR, v);  chk(v == 0, "R1 running count", v, 0);
        rd(A_USED, v); chk(v == 0, "R1 fill", v, 0);
        rd(A_SIZE, v); chk(v == DEPTH*4, "R2 capacity", v, DEPTH*4);
    endtask

    task automatic test_target_reset;
        wr(A_CTRL, 3); #1;
        chk(cfg_rst, "R10 reset high", cfg_rst, 1);
        wr(A_CTRL, 0); #1;
        chk(!cfg_rst, "R10 reset low", cfg_rst, 0);
    endtask

    task automatic test_cpu_load;
        logic [31:0] v; bit got; int base;
        logic [7:0] exp [8] = '{8'hA1, 8'hB2, 8'hC3, 8'hD4, 8'h11, 8'h22, 8'h33, 8'h44};
        wr(A_CTRL, 0); cfg_done = 1;
        wr(A_TOTAL, 8); base = ncap; req_cycles = 0;
        wr(A_CTRL, 1);
        wr(A_TOTAL, 100);
        rd(A_TOTAL, v); chk(v == 8, "R3 total locked while enabled", v, 8);
        wr(A_WIN, 32'hA1B2C3D4); wr(A_WIN, 32'h11223344); wr(A_WIN, 32'hDEADBEEF);
        wait_irq(200, got);
        chk(got, "R6 irq on completion", got, 1);
        chk(ncap - base == 8, "R4 byte count", ncap - base, 8);
        for (int i = 0; i < 8; i++)
            chk(cap[base+i] == exp[i], "R4 byte order", cap[base+i], exp[i]);
        rd(A_CUR, v);  chk(v == 8, "R5 running count", v, 8);
        rd(A_USED, v); chk(v == 4, "R5 extra word kept", v, 4);
        rd(A_STAT, v); chk(v[0] && (v[15:1] == 0), "R6 status ok", v, 32'h40001);
        chk(v[18], "R12 done mirrored", v, 32'h40001);
        chk(req_cycles == 0, "R11 no request in processor mode", req_cycles, 0);
        wr(A_CTRL, 1); #1;
        chk(irq, "R9 irq held on nonzero write", irq, 1);
        wr(A_CTRL, 0); #1;
        chk(!irq, "R9 irq cleared by zero", irq, 0);
        rd(A_USED, v); chk(v == 0, "R2 fill after flush", v, 0);
    endtask

    task automatic test_wait_done;
        logic [31:0] v; bit got;
        cfg_done = 0;
        wr(A_TOTAL, 4); wr(A_CTRL, 1); wr(A_WIN, 32'h01020304);
        repeat (30) @(negedge clk);
        chk(!irq, "R6 waits for done", irq, 0);
        rd(A_CUR, v); chk(v == 4, "R5 count reached", v, 4);
        rd(A_STAT, v); chk(v[18] == 0, "R12 done low", v, 0);
        cfg_done = 1;
        wait_irq(5, got);
        chk(got, "R6 irq after done", got, 1);
        wr(A_CTRL, 0);
    endtask

    task automatic test_target_err;
        logic [31:0] v; bit got;
        cfg_done = 0;
        wr(A_TOTAL, 16); wr(A_CTRL, 1); wr(A_WIN, 32'h55667788);
        @(negedge clk); cfg_err = 1; @(negedge clk); cfg_err = 0;
        wait_irq(20, got);
        chk(got, "R7 irq on target error", got, 1);
        rd(A_STAT, v); chk(v[1] && !v[0], "R7 status error", v, 2);
        wr(A_CTRL, 0);
    endtask

    task automatic test_overflow;
        logic [31:0] v; bit got; int base;
        cfg_done = 1;
        wr(A_CTRL, 0); wr(A_TOTAL, DEPTH*4);
        for (int i = 0; i <= DEPTH; i++) wr(A_WIN, 32'h0101_0000 + i);
        rd(A_USED, v); chk(v == DEPTH*4, "R8 fill stays full", v, DEPTH*4);
        rd(A_STAT, v); chk(v[2], "R8 overflow flag", v, 4);
        base = ncap;
        wr(A_CTRL, 1);
        rd(A_STAT, v); chk(v[15:1] == 0, "R8 flags cleared on start", v, 0);
        wait_irq(400, got);
        chk(got, "R6 irq after full image", got, 1);
        chk(ncap - base == DEPTH*4, "R8 dropped word not sent", ncap - base, DEPTH*4);
        v = {cap[base+DEPTH*4-4], cap[base+DEPTH*4-3], cap[base+DEPTH*4-2], cap[base+DEPTH*4-1]};
        chk(v == 32'h0101_0000 + DEPTH - 1, "R8 last word", v, 32'h0101_0000 + DEPTH - 1);
        wr(A_CTRL, 0);
    endtask

    task automatic test_dma;
        logic [31:0] v; bit got; int sent = 0; int base;
        cfg_done = 1;
        wr(A_TOTAL, DEPTH*8);
        #1; chk(!dma_req, "R11 idle no request", dma_req, 0);
        base = ncap;
        wr(A_CTRL, 5);
        while (sent < DEPTH*2) begin
            for (int w = 0; w < 200 && !dma_req; w++) @(negedge clk);
            for (int i = 0; i < DEPTH/2; i++) begin wr(A_WIN, 32'hC0DE_0000 + sent); sent++; end
            #1; chk(!dma_req, "R11 drop after burst", dma_req, 0);
        end
        wait_irq(400, got);
        chk(got, "R11 DMA load completes", got, 1);
        chk(ncap - base == DEPTH*8, "R4 DMA byte count", ncap - base, DEPTH*8);
        rd(A_CUR, v); chk(v == DEPTH*8, "R5 DMA running count", v, DEPTH*8);
        #1; chk(!dma_req, "R11 no request in FINISH", dma_req, 0);
        wr(A_CTRL, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual %0d expected %0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        test_reset();
        test_target_reset();
        test_cpu_load();
        test_wait_done();
        test_target_err();
        test_overflow();
        test_dma();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule